// File: doc/BRIEF.md
# Subword-Encoded Operand Register

This block is a one-stage register for 64-bit operands that never stores the word as one flat vector. Every accepted word is cut into eight fixed 8-bit subwords. Each subword gets a 2-bit class code: all zeros, all ones, or regular. A subword's 8-bit payload register is written only when its class is regular. An all-zero or all-one subword updates only its code, and its payload register keeps its old contents. On the read side, a decoder rebuilds each subword from its code. A constant subword comes from the code alone, and a regular subword comes from the stored payload.

Upstream logic presents a word together with a valid strobe. One cycle later the rebuilt word appears with its own valid. The per-lane write strobes are brought out, so power or activity tracking can see which payload lanes switched. Two running counters record how many lanes were skipped (special) and how many were written (regular). The stored codes and raw payload contents are also visible at the ports.

Top module: `subword_operand_reg`

## Requirements
- R1: Each stored subword code uses 2'b00 for an all-zero subword, 2'b01 for an all-one subword and 2'b10 for any other value. The code of subword i appears on `out_codes[2i+1:2i]`, and subword i is `in_word[8i+7:8i]`.
- R2: In the same cycle as the input, `lane_we[i]` is high exactly when `in_valid` is high and subword i is regular.
- R3: A payload register whose write strobe is low keeps its previous contents, as seen on `lane_data` (subword i in bits 8i+7:8i). One whose strobe is high takes the input subword at the clock edge.
- R4: `out_word` rebuilds subword i as 8'h00 for code 00, 8'hFF for code 01 and the stored payload for code 10, with subword 0 in bits 7:0. Every accepted word comes back bit-identical.
- R5: `out_valid` equals `in_valid` delayed by exactly one clock.
- R6: A synchronous active-high `rst` clears every code to 00, every payload to zero, both counters and `out_valid`. After reset, `out_word` therefore reads zero.
- R7: `special_count` grows, one clock after a valid input, by the number of that word's all-zero and all-one subwords, wrapping modulo 2^CNT_W.
- R8: `write_count` grows, one clock after a valid input, by the number of that word's regular subwords.
- R9: A cycle with `in_valid` low changes no code, payload, counter or `out_word`, whatever `in_word` holds.
- R10: `dec_err` is high only when a stored code is the reserved value 2'b11. Since encoding never produces that value, it stays low in operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 64 | Operand to encode and store |
| out_valid | output | 1 | Rebuilt word qualifier |
| out_word | output | 64 | Word rebuilt from codes and payloads |
| lane_we | output | 8 | Per-subword payload write strobes |
| out_codes | output | 16 | Stored 2-bit class code per subword |
| lane_data | output | 64 | Raw payload register contents |
| special_count | output | 32 | Running count of skipped (constant) subwords |
| write_count | output | 32 | Running count of payload writes |
| dec_err | output | 1 | Reserved code seen by the decoder |

## Verification
The write strobes are combinational, so they are due in the same cycle as the input. The bench samples them half a nanosecond after it drives the input, before the capturing edge. The codes, payloads, counters, `out_valid` and `out_word` all change at the first rising edge after a valid input. The bench samples these one nanosecond after that edge, against a model it advances only for valid inputs. Inputs are driven on falling edges, so idle cycles and reset are observed in the same position relative to the edge.

// File: rtl/swenc_pkg.sv
`timescale 1ns/1ps
package swenc_pkg;
  typedef enum logic [1:0] {
    CODE_ZERO = 2'b00,
    CODE_ONES = 2'b01,
    CODE_REG  = 2'b10,
    CODE_RSVD = 2'b11
  } sw_code_e;
endpackage

// File: rtl/swenc_classify.sv
`timescale 1ns/1ps
module swenc_classify
  import swenc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] sub_in,
  output sw_code_e          code,
  output logic              is_special
);
  logic all_zero;
  logic all_one;

  assign all_zero   = ~|sub_in;
  assign all_one    = &sub_in;
  assign is_special = all_zero | all_one;

  always_comb begin
    if (all_zero)     code = CODE_ZERO;
    else if (all_one) code = CODE_ONES;
    else              code = CODE_REG;
  end
endmodule

// File: rtl/swenc_lane_reg.sv
`timescale 1ns/1ps
module swenc_lane_reg
  import swenc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_en,
  input  sw_code_e          code_d,
  input  logic              pay_we,
  input  logic [LANE_W-1:0] pay_d,
  output sw_code_e          code_q,
  output logic [LANE_W-1:0] pay_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= CODE_ZERO;
      pay_q  <= '0;
    end else begin
      if (code_en) code_q <= code_d;
      if (pay_we)  pay_q  <= pay_d;
    end
  end
endmodule

// File: rtl/swenc_expand.sv
`timescale 1ns/1ps
module swenc_expand
  import swenc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  sw_code_e          code,
  input  logic [LANE_W-1:0] payload,
  output logic [LANE_W-1:0] sub_out,
  output logic              bad_code
);
  always_comb begin
    bad_code = 1'b0;
    unique case (code)
      CODE_ZERO: sub_out = '0;
      CODE_ONES: sub_out = '1;
      CODE_REG:  sub_out = payload;
      default: begin
        sub_out  = '0;
        bad_code = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/swenc_tally.sv
`timescale 1ns/1ps
module swenc_tally #(
  parameter int LANES = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [LANES-1:0] special_mask,
  output logic [CNT_W-1:0] skip_total,
  output logic [CNT_W-1:0] write_total
);
  localparam int NUM_W = $clog2(LANES + 1);

  function automatic logic [NUM_W-1:0] ones_in(input logic [LANES-1:0] m);
    logic [NUM_W-1:0] n;
    n = '0;
    for (int k = 0; k < LANES; k++) n = n + NUM_W'(m[k]);
    return n;
  endfunction

  logic [NUM_W-1:0] n_skip;
  logic [NUM_W-1:0] n_write;

  assign n_skip  = ones_in(special_mask);
  assign n_write = NUM_W'(LANES) - n_skip;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_total  <= '0;
      write_total <= '0;
    end else if (take) begin
      skip_total  <= skip_total + CNT_W'(n_skip);
      write_total <= write_total + CNT_W'(n_write);
    end
  end
endmodule

// File: rtl/subword_operand_reg.sv
`timescale 1ns/1ps
module subword_operand_reg
  import swenc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 32,
  localparam int LANES = WORD_W / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [WORD_W-1:0]    in_word,
  output logic                 out_valid,
  output logic [WORD_W-1:0]    out_word,
  output logic [LANES-1:0]     lane_we,
  output logic [2*LANES-1:0]   out_codes,
  output logic [WORD_W-1:0]    lane_data,
  output logic [CNT_W-1:0]     special_count,
  output logic [CNT_W-1:0]     write_count,
  output logic                 dec_err
);
  logic [LANES-1:0] special_mask;
  logic [LANES-1:0] bad_mask;
  logic             valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sw_code_e cls_code;
    sw_code_e held_code;

    swenc_classify #(.LANE_W(LANE_W)) u_cls (
      .sub_in     (in_word[g*LANE_W +: LANE_W]),
      .code       (cls_code),
      .is_special (special_mask[g])
    );

    assign lane_we[g] = in_valid & ~special_mask[g];

    swenc_lane_reg #(.LANE_W(LANE_W)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .code_en (in_valid),
      .code_d  (cls_code),
      .pay_we  (lane_we[g]),
      .pay_d   (in_word[g*LANE_W +: LANE_W]),
      .code_q  (held_code),
      .pay_q   (lane_data[g*LANE_W +: LANE_W])
    );

    assign out_codes[2*g +: 2] = held_code;

    swenc_expand #(.LANE_W(LANE_W)) u_exp (
      .code     (held_code),
      .payload  (lane_data[g*LANE_W +: LANE_W]),
      .sub_out  (out_word[g*LANE_W +: LANE_W]),
      .bad_code (bad_mask[g])
    );
  end

  swenc_tally #(.LANES(LANES), .CNT_W(CNT_W)) u_tally (
    .clk          (clk),
    .rst          (rst),
    .take         (in_valid),
    .special_mask (special_mask),
    .skip_total   (special_count),
    .write_total  (write_count)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
  end

  assign out_valid = valid_q;
  assign dec_err   = |bad_mask;
endmodule

// File: rtl/swenc_checker.sv
`timescale 1ns/1ps
module swenc_checker #(
  parameter int WORD_W = 64,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 32,
  localparam int LANES = WORD_W / LANE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [WORD_W-1:0]  in_word,
  input logic               out_valid,
  input logic [WORD_W-1:0]  out_word,
  input logic [LANES-1:0]   lane_we,
  input logic [2*LANES-1:0] out_codes,
  input logic [WORD_W-1:0]  lane_data,
  input logic [CNT_W-1:0]   special_count,
  input logic [CNT_W-1:0]   write_count,
  input logic               dec_err
);
  localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4
  round_trip_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word == $past(in_word)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_codes) && $stable(out_word) &&
                   $stable(special_count) && $stable(write_count)));
  // R2
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> (lane_we == '0));
  // R7 R8
  count_sum_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (CNT_W'((special_count - $past(special_count)) +
                         (write_count - $past(write_count))) == LANES_C));
  // R10
  no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_err);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R3
    pay_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !lane_we[g] |=> $stable(lane_data[g*LANE_W +: LANE_W]));
    // R3
    pay_load_chk: assert property (@(posedge clk) disable iff (rst)
      lane_we[g] |=> (lane_data[g*LANE_W +: LANE_W] ==
                      $past(in_word[g*LANE_W +: LANE_W])));
  end
endmodule

bind subword_operand_reg swenc_checker #(
  .WORD_W(WORD_W), .LANE_W(LANE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_word(out_word), .lane_we(lane_we),
  .out_codes(out_codes), .lane_data(lane_data),
  .special_count(special_count), .write_count(write_count),
  .dec_err(dec_err)
);

// File: tb/subword_operand_reg_test.sv
`timescale 1ns/1ps
module subword_operand_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic [63:0] out_word;
  logic [7:0]  lane_we;
  logic [15:0] out_codes;
  logic [63:0] lane_data;
  logic [31:0] special_count;
  logic [31:0] write_count;
  logic        dec_err;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_codes = '0;
  logic [63:0] m_pay   = '0;
  logic [31:0] m_spec  = '0;
  logic [31:0] m_wr    = '0;
  logic        m_ov    = 1'b0;

  localparam int NVEC = 12;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF, 64'h00FF_00FF_00FF_00FF,
    64'hFF00_A500_5A00_FF01, 64'h8000_0000_0000_00FF,
    64'hDEAD_BEEF_0000_0000, 64'hFFFF_FFFF_1234_5678,
    64'h0000_0000_0000_0001, 64'hFEFE_FEFE_0101_0101,
    64'h7FFF_FF00_00FF_FF80, 64'hFF00_FF00_FF00_FF00
  };

  always #2.5 clk = ~clk;

  subword_operand_reg uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .lane_we(lane_we),
    .out_codes(out_codes), .lane_data(lane_data),
    .special_count(special_count), .write_count(write_count),
    .dec_err(dec_err)
  );

  function automatic logic [1:0] class_of(input logic [7:0] b);
    if (b == 8'h00) return 2'b00;
    if (b == 8'hFF) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [63:0] rebuild(input logic [15:0] c, input logic [63:0] p);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) begin
      case (c[2*i +: 2])
        2'b00:   w[8*i +: 8] = 8'h00;
        2'b01:   w[8*i +: 8] = 8'hFF;
        default: w[8*i +: 8] = p[8*i +: 8];
      endcase
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outputs();
    check("R5 out_valid", 64'(out_valid), 64'(m_ov));
    check("R1 out_codes", 64'(out_codes), 64'(m_codes));
    check("R3 lane_data", lane_data, m_pay);
    check("R4 out_word", out_word, rebuild(m_codes, m_pay));
    check("R7 special_count", 64'(special_count), 64'(m_spec));
    check("R8 write_count", 64'(write_count), 64'(m_wr));
    check("R10 dec_err", 64'(dec_err), 64'd0);
  endtask

  task automatic step(input logic v, input logic [63:0] w);
    logic [7:0] exp_we;
    @(negedge clk);
    in_valid = v;
    in_word  = w;
    #0.5;
    for (int i = 0; i < 8; i++)
      exp_we[i] = v && (class_of(w[8*i +: 8]) == 2'b10);
    check("R2 lane_we", 64'(lane_we), 64'(exp_we));
    if (v) begin
      for (int i = 0; i < 8; i++) begin
        m_codes[2*i +: 2] = class_of(w[8*i +: 8]);
        if (exp_we[i]) begin
          m_pay[8*i +: 8] = w[8*i +: 8];
          m_wr = m_wr + 1;
        end else begin
          m_spec = m_spec + 1;
        end
      end
    end
    m_ov = v;
    @(posedge clk);
    #1;
    check_outputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    m_codes = '0; m_pay = '0; m_spec = '0; m_wr = '0; m_ov = 1'b0;
    check("R6 out_valid", 64'(out_valid), 64'd0);
    check("R6 out_codes", 64'(out_codes), 64'd0);
    check("R6 out_word", out_word, 64'd0);
    check("R6 lane_data", lane_data, 64'd0);
    check("R6 special_count", 64'(special_count), 64'd0);
    check("R6 write_count", 64'(write_count), 64'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset();

    // R4 R1 R7 R8: walk the vector table back to back
    for (int k = 0; k < NVEC; k++) step(1'b1, VEC[k]);
    // R5: valid drops one cycle after the input stops
    step(1'b0, 64'h0);

    // R4: direct round-trip comparisons against the input word
    for (int k = 0; k < NVEC; k++) begin
      step(1'b1, VEC[k]);
      check("R4 round trip", out_word, VEC[k]);
    end

    // R9: garbage on in_word with valid low changes nothing
    step(1'b0, 64'h5A5A_1234_DEAD_BEEF);
    step(1'b0, 64'hFFFF_0000_ABCD_0000);

    // R3: constant subwords leave earlier payloads in place
    step(1'b1, 64'h1122_3344_5566_77AB);
    step(1'b1, 64'h0000_FFFF_0000_FFFF);
    check("R3 payload kept", lane_data, 64'h1122_3344_5566_77AB);
    step(1'b1, 64'h00FF_3C00_FF00_C3FF);
    check("R3 partial write", lane_data, 64'h1122_3C44_5566_C3AB);

    // R5: alternate valid and idle
    step(1'b1, 64'h0102_0304_0506_0708);
    step(1'b0, 64'h0);
    step(1'b1, 64'hFFFF_FFFF_FFFF_FF7E);

    // R6: reset in mid run, then traffic again
    do_reset();
    step(1'b1, 64'h00FF_0000_0000_0000);
    check("R7 count after reset", 64'(special_count), 64'd8);
    step(1'b1, 64'h9988_7766_5544_3322);
    check("R8 count after reset", 64'(write_count), 64'd8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule